// File: doc/BRIEF.md
# Bidirectional Universal Bus Register

This block carries two independent 18-bit data paths between an A side and a B side: one path moves A data toward B, the other moves B data toward A. Each path holds one storage element whose behaviour is set by three controls. A high latch enable makes the path transparent, so the output follows the input in the same cycle. With the latch enable low, the path either keeps its stored word or captures a new one when its capture strobe rises. The strobe is gated by an active-low strobe enable. An active-low output enable decides whether the port is driven.

The block runs on one system clock. Each capture strobe is a level input that is sampled on that clock, and a rising transition is detected between two consecutive clock edges. A tri-state pin is represented by a value bus plus a single drive-enable bit per port, and the pad logic outside the block combines the two. Both directions use one shared path module, instantiated twice.

Top module: `ubr_top`

## Requirements
- R1: Each data path is WIDTH bits wide, 18 by default, and every bit position, including bit 17, passes through to the output.
- R2: While a path's latch enable is 1, its output value equals its input bus combinationally, in the same cycle.
- R3: While the latch enable is 0 and no rising strobe is seen at a clock edge, the path's output value stays unchanged across that edge.
- R4: With the latch enable at 0 and the strobe enable at 0, a strobe sampled 0 at one clock edge and 1 at the next captures the input present at that second edge. The captured word appears on the output right after that edge.
- R5: While the strobe enable is 1, a rising strobe captures nothing and the output value holds.
- R6: A port's drive-enable output is 1 exactly when its output enable is 0. It is never 1 while the output enable is 1.
- R7: When the latch enable drops to 0, the path keeps the input word sampled at the last clock edge on which the latch enable was 1.
- R8: Setting the output enable to 1 leaves the stored word untouched. Setting it back to 0 presents the same stored word with drive asserted.
- R9: Activity on one direction (latch, capture) never changes the other direction's output value.
- R10: During and after reset (active-low rstN), the stored word of each path is 0. A path with its latch enable at 0 therefore outputs 0 until it captures.
- R11: A strobe that is already 1 when reset is released is not taken as a rising edge. A capture needs the strobe to be sampled 0 at some edge after reset first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| aIn | input | 18 | Value read from the A-side pins |
| bIn | input | 18 | Value read from the B-side pins |
| latchAb | input | 1 | Latch enable, A-to-B path (1 = transparent) |
| strobeAb | input | 1 | Capture strobe, A-to-B path |
| strobeEnAbN | input | 1 | Active-low strobe enable, A-to-B path |
| outEnAbN | input | 1 | Active-low output enable of the B port |
| latchBa | input | 1 | Latch enable, B-to-A path |
| strobeBa | input | 1 | Capture strobe, B-to-A path |
| strobeEnBaN | input | 1 | Active-low strobe enable, B-to-A path |
| outEnBaN | input | 1 | Active-low output enable of the A port |
| bOut | output | 18 | Value for the B-side pins |
| bDrive | output | 1 | Drive enable of the B-side pins |
| aOut | output | 18 | Value for the A-side pins |
| aDrive | output | 1 | Drive enable of the A-side pins |

## Verification
Transparent data and drive enables are combinational, so they are due in the same cycle as the stimulus. A stored word changes only at the clock edge where the capture condition holds, and it is visible from that edge onward. The bench applies inputs shortly after each rising edge and samples every output at the falling edge. Its reference model updates at the rising edge from the inputs applied before it, so each comparison lines up with exactly one edge of state change. Directed sequences take each mode change and each strobe-enable case in both directions, and a randomized stretch compares the outputs on every cycle.

// File: rtl/ubr_pkg.sv
package ubr_pkg;
  // Strobes from a path's control to its datapath
  typedef struct packed {
    logic pass;     // transparent: follow and track the input
    logic capture;  // load the input on this clock edge
    logic drive;    // port drive enable
  } ubrStrobes_t;
endpackage

// File: rtl/ubr_ctrl.sv
module ubr_ctrl
  import ubr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        latchEn,
  input  logic        strobe,
  input  logic        strobeEnN,
  input  logic        outEnN,
  output ubrStrobes_t ctl
);
  logic strobePrev;

  // Reset to 1 so a strobe held high through reset is not an edge
  always_ff @(posedge clk) begin
    if (!rstN) strobePrev <= 1'b1;
    else       strobePrev <= strobe;
  end

  always_comb begin
    ctl.pass    = latchEn;
    ctl.capture = !latchEn && strobe && !strobePrev && !strobeEnN;
    ctl.drive   = !outEnN;
  end
endmodule

// File: rtl/ubr_datapath.sv
module ubr_datapath
  import ubr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  ubrStrobes_t      ctl,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut,
  output logic             drive
);
  logic [WIDTH-1:0] stored;

  always_ff @(posedge clk) begin
    if (!rstN)                       stored <= '0;
    else if (ctl.pass || ctl.capture) stored <= dIn;
  end

  assign dOut  = ctl.pass ? dIn : stored;
  assign drive = ctl.drive;
endmodule

// File: rtl/ubr_path.sv
module ubr_path
  import ubr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  input  logic             latchEn,
  input  logic             strobe,
  input  logic             strobeEnN,
  input  logic             outEnN,
  output logic [WIDTH-1:0] dOut,
  output logic             drive
);
  ubrStrobes_t ctl;

  ubr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .latchEn(latchEn), .strobe(strobe),
    .strobeEnN(strobeEnN), .outEnN(outEnN), .ctl(ctl)
  );

  ubr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dIn(dIn), .dOut(dOut), .drive(drive)
  );
endmodule

// File: rtl/ubr_top.sv
module ubr_top #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic             latchAb,
  input  logic             strobeAb,
  input  logic             strobeEnAbN,
  input  logic             outEnAbN,
  input  logic             latchBa,
  input  logic             strobeBa,
  input  logic             strobeEnBaN,
  input  logic             outEnBaN,
  output logic [WIDTH-1:0] bOut,
  output logic             bDrive,
  output logic [WIDTH-1:0] aOut,
  output logic             aDrive
);
  ubr_path #(.WIDTH(WIDTH)) u_abPath (
    .clk(clk), .rstN(rstN), .dIn(aIn), .latchEn(latchAb), .strobe(strobeAb),
    .strobeEnN(strobeEnAbN), .outEnN(outEnAbN), .dOut(bOut), .drive(bDrive)
  );

  ubr_path #(.WIDTH(WIDTH)) u_baPath (
    .clk(clk), .rstN(rstN), .dIn(bIn), .latchEn(latchBa), .strobe(strobeBa),
    .strobeEnN(strobeEnBaN), .outEnN(outEnBaN), .dOut(aOut), .drive(aDrive)
  );
endmodule

// File: rtl/ubr_checker.sv
module ubr_checker #(
  parameter int WIDTH = 18
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] aIn,
  input logic [WIDTH-1:0] bIn,
  input logic             latchAb,
  input logic             strobeAb,
  input logic             strobeEnAbN,
  input logic             outEnAbN,
  input logic             latchBa,
  input logic             strobeBa,
  input logic             strobeEnBaN,
  input logic             outEnBaN,
  input logic [WIDTH-1:0] bOut,
  input logic             bDrive,
  input logic [WIDTH-1:0] aOut,
  input logic             aDrive
);
  a_r2_pass_ab: assert property (@(posedge clk) disable iff (!rstN)
    latchAb |-> bOut == aIn);
  a_r2_pass_ba: assert property (@(posedge clk) disable iff (!rstN)
    latchBa |-> aOut == bIn);

  a_r3_hold_ab: assert property (@(posedge clk) disable iff (!rstN)
    (!latchAb && !strobeAb) |=> (latchAb || bOut == $past(bOut)));
  a_r3_hold_ba: assert property (@(posedge clk) disable iff (!rstN)
    (!latchBa && !strobeBa) |=> (latchBa || aOut == $past(aOut)));

  a_r4_capture_ab: assert property (@(posedge clk) disable iff (!rstN)
    (!latchAb && !strobeEnAbN && strobeAb && !$past(strobeAb) && $past(rstN))
      |=> (latchAb || bOut == $past(aIn)));
  a_r4_capture_ba: assert property (@(posedge clk) disable iff (!rstN)
    (!latchBa && !strobeEnBaN && strobeBa && !$past(strobeBa) && $past(rstN))
      |=> (latchBa || aOut == $past(bIn)));

  a_r5_gated_ab: assert property (@(posedge clk) disable iff (!rstN)
    (!latchAb && strobeEnAbN) |=> (latchAb || bOut == $past(bOut)));
  a_r5_gated_ba: assert property (@(posedge clk) disable iff (!rstN)
    (!latchBa && strobeEnBaN) |=> (latchBa || aOut == $past(aOut)));

  a_r6_drive_b: assert property (@(posedge clk) disable iff (!rstN)
    outEnAbN |-> !bDrive);
  a_r6_drive_a: assert property (@(posedge clk) disable iff (!rstN)
    outEnBaN |-> !aDrive);
endmodule

bind ubr_top ubr_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .aIn(aIn), .bIn(bIn),
  .latchAb(latchAb), .strobeAb(strobeAb), .strobeEnAbN(strobeEnAbN), .outEnAbN(outEnAbN),
  .latchBa(latchBa), .strobeBa(strobeBa), .strobeEnBaN(strobeEnBaN), .outEnBaN(outEnBaN),
  .bOut(bOut), .bDrive(bDrive), .aOut(aOut), .aDrive(aDrive)
);

// File: tb/tb_ubr_top.sv
module tb_ubr_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic latchAb = 1'b0, strobeAb = 1'b1, strobeEnAbN = 1'b0, outEnAbN = 1'b1;
  logic latchBa = 1'b0, strobeBa = 1'b1, strobeEnBaN = 1'b0, outEnBaN = 1'b1;
  logic [W-1:0] bOut, aOut;
  logic bDrive, aDrive;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  // Behavioural reference state
  logic [W-1:0] refB = '0, refA = '0;
  int prevAb = 1, prevBa = 1;
  string tagAb = "R10", tagBa = "R10";

  ubr_top #(.WIDTH(W)) dut (
    .clk(clk), .rstN(rstN), .aIn(aIn), .bIn(bIn),
    .latchAb(latchAb), .strobeAb(strobeAb), .strobeEnAbN(strobeEnAbN), .outEnAbN(outEnAbN),
    .latchBa(latchBa), .strobeBa(strobeBa), .strobeEnBaN(strobeEnBaN), .outEnBaN(outEnBaN),
    .bOut(bOut), .bDrive(bDrive), .aOut(aOut), .aDrive(aDrive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: updates on each clock edge from the applied inputs
  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      refB = '0; refA = '0; prevAb = 1; prevBa = 1;
      tagAb = "R10"; tagBa = "R10";
    end else begin
      if (latchAb) begin refB = aIn; tagAb = "R7"; end
      else if (strobeAb && prevAb == 0 && !strobeEnAbN) begin refB = aIn; tagAb = "R4"; end
      else if (strobeAb && prevAb == 0) tagAb = "R5";
      else tagAb = "R3";
      if (latchBa) begin refA = bIn; tagBa = "R7"; end
      else if (strobeBa && prevBa == 0 && !strobeEnBaN) begin refA = bIn; tagBa = "R4"; end
      else if (strobeBa && prevBa == 0) tagBa = "R5";
      else tagBa = "R3";
      prevAb = strobeAb ? 1 : 0;
      prevBa = strobeBa ? 1 : 0;
    end
  end

  // Compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(latchAb ? "R2" : tagAb, bOut, latchAb ? aIn : refB);
      chk(latchBa ? "R2" : tagBa, aOut, latchBa ? bIn : refA);
      chk("R6", {{(W-1){1'b0}}, bDrive}, {{(W-1){1'b0}}, !outEnAbN});
      chk("R6", {{(W-1){1'b0}}, aDrive}, {{(W-1){1'b0}}, !outEnBaN});
    end
  end

  task automatic nextCycle();
    @(posedge clk); #2;
  endtask

  task automatic atSample();
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    logic [W-1:0] held;
    // Reset with strobes high (R11)
    repeat (3) nextCycle();
    atSample();
    chk("R10", bOut, '0);
    chk("R10", aOut, '0);
    chk("R6", {{(W-1){1'b0}}, bDrive}, '0);
    nextCycle();
    rstN = 1'b1; aIn = 18'h2AAAA; bIn = 18'h15555;
    // Strobe stays high: no rising edge seen after reset (R11)
    nextCycle(); nextCycle();
    atSample();
    chk("R11", bOut, '0);
    chk("R11", aOut, '0);

    // R1 + R2: transparent, full width including bit 17
    nextCycle();
    outEnAbN = 1'b0; outEnBaN = 1'b0;
    latchAb = 1'b1; aIn = 18'h20001;
    latchBa = 1'b1; bIn = 18'h3FFFF;
    atSample();
    chk("R1", bOut, 18'h20001);
    chk("R1", aOut, 18'h3FFFF);
    chk("R6", {{(W-1){1'b0}}, bDrive}, 18'd1);

    // R7: latch enable falls, last transparent word kept
    nextCycle();
    aIn = 18'h0BEEF; bIn = 18'h1CAFE;
    nextCycle();
    latchAb = 1'b0; latchBa = 1'b0; aIn = 18'h11111; bIn = 18'h22222;
    atSample();
    chk("R7", bOut, 18'h0BEEF);
    chk("R7", aOut, 18'h1CAFE);

    // R5: strobe enable high, rising strobe ignored (both directions)
    nextCycle();
    strobeAb = 1'b0; strobeBa = 1'b0; strobeEnAbN = 1'b1; strobeEnBaN = 1'b1;
    nextCycle();
    strobeAb = 1'b1; strobeBa = 1'b1;
    nextCycle();
    atSample();
    chk("R5", bOut, 18'h0BEEF);
    chk("R5", aOut, 18'h1CAFE);

    // R4: enabled capture on A-to-B only; R9: B-to-A unaffected
    nextCycle();
    strobeAb = 1'b0; strobeBa = 1'b0; strobeEnAbN = 1'b0;
    nextCycle();
    strobeAb = 1'b1; aIn = 18'h33333;
    atSample();
    chk("R4", bOut, 18'h0BEEF);
    nextCycle();
    aIn = 18'h00004;
    atSample();
    chk("R4", bOut, 18'h33333);
    chk("R9", aOut, 18'h1CAFE);

    // R3: strobe held high, input changes, no capture
    nextCycle(); nextCycle();
    atSample();
    chk("R3", bOut, 18'h33333);

    // R4 on B-to-A; R9: A-to-B unaffected
    strobeEnBaN = 1'b0;
    nextCycle();
    strobeBa = 1'b1; bIn = 18'h2F0F0;
    nextCycle();
    atSample();
    chk("R4", aOut, 18'h2F0F0);
    chk("R9", bOut, 18'h33333);

    // R8: output disabled, state untouched, re-enable presents it
    nextCycle();
    outEnAbN = 1'b1; strobeAb = 1'b0; strobeEnAbN = 1'b1;
    held = bOut;
    nextCycle();
    strobeAb = 1'b1; aIn = 18'h3C3C3;
    atSample();
    chk("R6", {{(W-1){1'b0}}, bDrive}, '0);
    nextCycle();
    outEnAbN = 1'b0;
    atSample();
    chk("R8", bOut, held);
    chk("R8", {{(W-1){1'b0}}, bDrive}, 18'd1);

    // Randomized stretch, compared every cycle by the monitor
    for (int i = 0; i < 400; i++) begin
      nextCycle();
      aIn = W'($urandom); bIn = W'($urandom);
      latchAb = ($urandom % 4) == 0; latchBa = ($urandom % 4) == 0;
      strobeAb = $urandom % 2; strobeBa = $urandom % 2;
      strobeEnAbN = ($urandom % 3) == 0; strobeEnBaN = ($urandom % 3) == 0;
      outEnAbN = $urandom % 2; outEnBaN = $urandom % 2;
    end
    atSample();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule